// File: doc/BRIEF.md
# Laser Transmitter Safety Controller

This block governs whether a pluggable module's laser may emit light. It steps through power-up initialisation and follows the host's transmit-disable pin. It catches safety faults from the module's internal fault detector, latches them, and reports them to the host on a fault output. A latched fault can only be released by a deliberate host action. The host must hold disable high for at least a minimum number of cycles and then let it go low. After that the controller runs initialisation again and checks whether the fault is still there.

Every deadline is a parameter counted in clock cycles. The init window is `INIT_CYC`. The minimum disable hold that clears a fault is `HOLD_CYC`. The host pin passes through a two-flop synchroniser whose flops reset to the disabled level. An undriven pin is pulled high at the pad, so it reads as disabled. The fault detector and power-good are on-chip and synchronous to `clk_i`.

Top module: `tx_safety_ctrl`

## Requirements
- R1: While power-good is low, including straight after reset, `laser_en_o` and `tx_fault_o` are both 0, whatever the other inputs do.
- R2: When `pwr_good_i` is first sampled high at edge p with disable settled low, `laser_en_o` stays 0 through edge p+INIT_CYC and is 1 after edge p+INIT_CYC+1.
- R3: If disable is settled high when initialisation ends, the laser stays off and `tx_fault_o` stays 0.
- R4: In normal operation, `laser_en_o` falls after the third rising edge at which `tx_disable_i` is sampled high. It is still 1 after the second such edge.
- R5: `laser_en_o` rises after the third rising edge at which `tx_disable_i` is sampled low, when no fault is latched.
- R6: When `fault_det_i` is sampled high in normal operation, with the laser on or off, `tx_fault_o` is 1 and `laser_en_o` is 0 after that same edge.
- R7: A fault present at the end of initialisation is reported at that moment: `tx_fault_o` rises after edge p+INIT_CYC+1.
- R8: A latched fault stays latched after `fault_det_i` returns low, with disable low. `laser_en_o` stays 0.
- R9: A disable pulse sampled high for fewer than HOLD_CYC edges leaves the fault latched and the laser off.
- R10: A disable pulse sampled high for at least HOLD_CYC edges and then sampled low clears `tx_fault_o` after the third low edge. The block then runs a new initialisation of INIT_CYC+1 cycles.
- R11: At the end of that re-initialisation, a fault that is still present makes `tx_fault_o` rise again. If the fault was transient, the laser turns on (disable low) and `tx_fault_o` stays 0.
- R12: Loss of power-good in any state drives both outputs to 0 after the next edge, and it discards a latched fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_good_i | input | 1 | Supply valid, synchronous |
| tx_disable_i | input | 1 | Host disable pin, asynchronous, high or open means off |
| fault_det_i | input | 1 | Internal safety fault detector, synchronous |
| laser_en_o | output | 1 | Laser drive permitted |
| tx_fault_o | output | 1 | Latched fault report to host |

## Verification
The embedded properties check several rules on every cycle. A synchronised disable always forces the laser off on the next edge. A detected fault in normal operation always raises the fault output and drops the laser. Power loss always clears both outputs. The fault output never falls except through power loss or a completed hold-and-release. The timers never count past their limits. Other behaviour only the directed scenarios can show: the exact init length, the synchroniser latency on both edges of disable, the one-cycle difference between a too-short and a sufficient reset pulse, and the different outcomes of re-initialisation after transient and persistent faults.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_INIT = 3'd1,
    ST_DIS  = 3'd2,
    ST_ACT  = 3'd3,
    ST_FLT  = 3'd4
  } tsc_state_e;
endpackage

// File: rtl/tsc_sync.sv
module tsc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= RST_VAL;
        else         sr_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/tsc_timer.sv
// Saturating cycle counter; clear wins over increment.
module tsc_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic done_o
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                  cnt_q <= '0;
    else if (clr_i)               cnt_q <= '0;
    else if (inc_i && cnt_q != LIM) cnt_q <= cnt_q + 1'b1;

  assign done_o = (cnt_q == LIM);

  p_cnt_bound_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIM);
  p_cnt_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !done_o);
endmodule

// File: rtl/tsc_fsm.sv
module tsc_fsm
  import tsc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_good_i,
  input  logic dis_i,
  input  logic fault_i,
  input  logic init_done_i,
  input  logic hold_done_i,
  output logic init_run_o,
  output logic hold_run_o,
  output logic laser_en_o,
  output logic tx_fault_o
);
  tsc_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!pwr_good_i) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:  state_d = ST_INIT;
        ST_INIT: if (init_done_i) begin
                   if (fault_i)    state_d = ST_FLT;
                   else if (dis_i) state_d = ST_DIS;
                   else            state_d = ST_ACT;
                 end
        ST_DIS:  if (fault_i)      state_d = ST_FLT;
                 else if (!dis_i)  state_d = ST_ACT;
        ST_ACT:  if (fault_i)      state_d = ST_FLT;
                 else if (dis_i)   state_d = ST_DIS;
        ST_FLT:  if (!dis_i && hold_done_i) state_d = ST_INIT;
        default: state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) state_q <= ST_OFF;
    else         state_q <= state_d;

  assign init_run_o = (state_q == ST_INIT);
  assign hold_run_o = (state_q == ST_FLT) && dis_i;
  assign laser_en_o = (state_q == ST_ACT);
  assign tx_fault_o = (state_q == ST_FLT);

  p_pwr_loss_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |=> !laser_en_o && !tx_fault_o);
  p_dis_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_i |=> !laser_en_o);
  p_fault_report_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_good_i && fault_i && (state_q == ST_ACT || state_q == ST_DIS))
      |=> tx_fault_o && !laser_en_o);
  p_fault_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_fault_o) |-> (!$past(pwr_good_i) || ($past(hold_done_i) && !$past(dis_i))));
  p_enable_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(laser_en_o) |-> !$past(dis_i) && !$past(fault_i));
endmodule

// File: rtl/tx_safety_ctrl.sv
module tx_safety_ctrl #(
  parameter int INIT_CYC    = 30_000_000,
  parameter int HOLD_CYC    = 1_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_good_i,
  input  logic tx_disable_i,
  input  logic fault_det_i,
  output logic laser_en_o,
  output logic tx_fault_o
);
  logic dis_s;
  logic init_run, init_done;
  logic hold_run, hold_done;

  tsc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (tx_disable_i),
    .q_o   (dis_s)
  );

  tsc_timer #(.LIMIT(INIT_CYC)) u_init_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (!init_run),
    .inc_i (init_run),
    .done_o(init_done)
  );

  tsc_timer #(.LIMIT(HOLD_CYC)) u_hold_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (!hold_run),
    .inc_i (hold_run),
    .done_o(hold_done)
  );

  tsc_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pwr_good_i (pwr_good_i),
    .dis_i      (dis_s),
    .fault_i    (fault_det_i),
    .init_done_i(init_done),
    .hold_done_i(hold_done),
    .init_run_o (init_run),
    .hold_run_o (hold_run),
    .laser_en_o (laser_en_o),
    .tx_fault_o (tx_fault_o)
  );
endmodule

// File: tb/tb_tx_safety_ctrl.sv
module tb_tx_safety_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int INIT_CYC   = 20;
  localparam int HOLD_CYC   = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pwr_good = 1'b0;
  logic tx_disable = 1'b1;
  logic fault_det = 1'b0;
  logic laser_en, tx_fault;
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_safety_ctrl #(.INIT_CYC(INIT_CYC), .HOLD_CYC(HOLD_CYC), .SYNC_STAGES(2)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .pwr_good_i(pwr_good),
    .tx_disable_i(tx_disable), .fault_det_i(fault_det),
    .laser_en_o(laser_en), .tx_fault_o(tx_fault)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // Power up from off; disable level set beforehand and allowed to settle.
  task automatic power_up(input logic dis, input logic flt);
    pwr_good = 1'b0; tx_disable = dis; fault_det = flt;
    tick(4);
    pwr_good = 1'b1;
    tick(1 + INIT_CYC);
  endtask

  task automatic t_reset;
    check("R1 laser off in reset", laser_en, 1'b0);
    check("R1 fault low in reset", tx_fault, 1'b0);
    rst_ni = 1'b1;
    tx_disable = 1'b0; fault_det = 1'b1;
    tick(6);
    check("R1 laser off without power", laser_en, 1'b0);
    check("R1 fault low without power", tx_fault, 1'b0);
    fault_det = 1'b0;
  endtask

  task automatic t_powerup_active;
    power_up(1'b0, 1'b0);
    check("R2 laser off at end of init window", laser_en, 1'b0);
    tick(1);
    check("R2 laser on after init", laser_en, 1'b1);
    check("R2 no fault after init", tx_fault, 1'b0);
  endtask

  task automatic t_disable_timing;
    tx_disable = 1'b1;
    tick(2);
    check("R4 laser still on after two high samples", laser_en, 1'b1);
    tick(1);
    check("R4 laser off after third high sample", laser_en, 1'b0);
    tick(3);
    tx_disable = 1'b0;
    tick(2);
    check("R5 laser still off after two low samples", laser_en, 1'b0);
    tick(1);
    check("R5 laser on after third low sample", laser_en, 1'b1);
  endtask

  task automatic t_powerup_disabled;
    power_up(1'b1, 1'b0);
    tick(3);
    check("R3 laser off when disabled at init end", laser_en, 1'b0);
    check("R3 no fault when disabled at init end", tx_fault, 1'b0);
    // fault while disabled
    fault_det = 1'b1;
    tick(1);
    check("R6 fault reported while disabled", tx_fault, 1'b1);
    fault_det = 1'b0;
    tx_disable = 1'b0;
  endtask

  task automatic t_fault_active;
    power_up(1'b0, 1'b0);
    tick(1);
    check("R2 laser on before fault", laser_en, 1'b1);
    fault_det = 1'b1;
    tick(1);
    check("R6 fault reported", tx_fault, 1'b1);
    check("R6 laser shut off", laser_en, 1'b0);
    fault_det = 1'b0;
    tick(10);
    check("R8 fault stays latched", tx_fault, 1'b1);
    check("R8 laser stays off", laser_en, 1'b0);
  endtask

  task automatic t_short_pulse;
    tx_disable = 1'b1;
    tick(HOLD_CYC - 1);
    tx_disable = 1'b0;
    tick(6);
    check("R9 short pulse keeps fault", tx_fault, 1'b1);
    check("R9 short pulse keeps laser off", laser_en, 1'b0);
  endtask

  // Issue a qualifying clear pulse; returns just after the clearing edge.
  task automatic clear_pulse;
    tx_disable = 1'b1;
    tick(HOLD_CYC);
    tx_disable = 1'b0;
    tick(2);
    check("R10 fault held until third low sample", tx_fault, 1'b1);
    tick(1);
    check("R10 fault cleared by hold and release", tx_fault, 1'b0);
  endtask

  task automatic t_clear_transient;
    clear_pulse();
    tick(INIT_CYC);
    check("R10 laser off during re-init", laser_en, 1'b0);
    tick(1);
    check("R11 transient fault recovers laser", laser_en, 1'b1);
    check("R11 transient fault stays clear", tx_fault, 1'b0);
  endtask

  task automatic t_clear_persistent;
    fault_det = 1'b1;
    tick(1);
    check("R6 fault reported again", tx_fault, 1'b1);
    clear_pulse();
    tick(INIT_CYC);
    check("R11 fault clear during re-init", tx_fault, 1'b0);
    tick(1);
    check("R11 persistent fault re-reported", tx_fault, 1'b1);
    check("R11 laser off with persistent fault", laser_en, 1'b0);
  endtask

  task automatic t_pwr_loss;
    pwr_good = 1'b0;
    tick(1);
    check("R12 power loss clears fault", tx_fault, 1'b0);
    check("R12 power loss laser off", laser_en, 1'b0);
    fault_det = 1'b0;
    power_up(1'b0, 1'b0);
    tick(1);
    check("R12 fresh init after power loss", laser_en, 1'b1);
    pwr_good = 1'b0;
    tick(1);
    check("R12 power loss from active", laser_en, 1'b0);
  endtask

  task automatic t_fault_in_init;
    power_up(1'b0, 1'b1);
    check("R7 fault not reported before init end", tx_fault, 1'b0);
    tick(1);
    check("R7 fault reported at init end", tx_fault, 1'b1);
    check("R7 laser off at init end with fault", laser_en, 1'b0);
    pwr_good = 1'b0; fault_det = 1'b0;
    tick(1);
  endtask

  initial begin
    tick(3);
    t_reset();
    t_powerup_active();
    t_disable_timing();
    t_powerup_disabled();
    t_fault_active();
    t_short_pulse();
    t_clear_transient();
    t_clear_persistent();
    t_pwr_loss();
    t_fault_in_init();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule